// File: doc/BRIEF.md
# Corrected Error Threshold Counter

This block is one error-reporting bank. Each pulse on its corrected-error input adds one to a 15-bit count that sits inside a 64-bit status word, and it sets the valid flag of that word. Software programs a threshold and two enables: a global capability enable and a per-bank enable. When both enables are on and a corrected error brings the count up to the threshold, the bank raises a one-cycle interrupt request.

The request goes to every processor that shares the failing resource. An input mask selects those processors, one bit per target, and each selected target receives the pulse in the same cycle. Software clears the status word by writing it with the valid flag low, which also zeroes the count. When the bank is built without threshold support, the threshold and the bank enable always read back as zero and no interrupt is ever raised.

Top module: `ce_threshold_bank`

## Requirements
- R1: After reset the capability word, the control word, the status word and the interrupt request output are all zero.
- R2: An interrupt needs both enables set in the cycle of the error: bit 10 of the capability word (written with wr_sel=0) and bit 30 of the control word (written with wr_sel=1). Bits 14:0 of the control word hold the threshold. All other bits of these two words read zero.
- R3: A corrected-error pulse with no status write in the same cycle sets status bit 63 (valid) and adds one to the count in status bits 52:38. Both changes are visible one cycle later.
- R4: The count stops at 32767 and does not wrap.
- R5: Suppose a pulse moves the count from a value not equal to the effective threshold to a value equal to it, with both enables on. Then on the next cycle, irq equals the share_mask value that was present with the pulse. In every other cycle irq is zero.
- R6: The interrupt fires only on the first cycle of equality. Further pulses while the count stays at the threshold do not fire again (this covers the saturated count). A software load of a count equal to the threshold does not fire either.
- R7: A programmed threshold of zero behaves as a threshold of one. It still reads back as zero.
- R8: A status write (wr_sel=2) with bit 63 low zeroes both the valid flag and the count. With bit 63 high it sets valid and loads the count from bits 52:38. A status write takes priority over a corrected-error pulse in the same cycle, and that pulse is dropped.
- R9: With SUPPORTED=0, the threshold field and the bank enable read as zero and irq stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_strobe | input | 1 | One pulse per corrected error |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 capability, 1 control, 2 status |
| wr_data | input | 64 | Write data |
| share_mask | input | N_TGT | Processors that share the resource |
| cap_rd | output | 32 | Capability word readback |
| ctl_rd | output | 32 | Control word readback |
| status_rd | output | 64 | Status word (valid flag and count) |
| irq | output | N_TGT | Threshold interrupt request, one bit per target |

## Verification
The bench targets the equality edge. It checks that a count loaded by software to the threshold value stays silent, and that further errors at a saturated threshold do not fire again. A design that compared with greater-or-equal, or compared only the new value, would emit repeated pulses in those cases. The bench also programs a zero threshold, where a design without the substitution to one would never interrupt. It drives a status write in the same cycle as an error, where a wrong priority would leave a count of one behind. Finally, it runs with one enable at a time, where a design that checks only one level would interrupt anyway.

// File: rtl/ce_bank_pkg.sv
package ce_bank_pkg;
  localparam int unsigned CE_CNT_W = 15;
  typedef logic [CE_CNT_W-1:0] ce_cnt_t;

  typedef enum logic [1:0] {
    SEL_CAP = 2'd0,
    SEL_CTL = 2'd1,
    SEL_STS = 2'd2,
    SEL_NONE = 2'd3
  } ce_sel_e;

  // Saturating increment of the count field.
  function automatic ce_cnt_t ce_sat_inc(input ce_cnt_t c);
    return (c == '1) ? c : ce_cnt_t'(c + 1'b1);
  endfunction

  // A zero threshold is substituted by one.
  function automatic ce_cnt_t ce_eff_thr(input ce_cnt_t t);
    return (t == '0) ? ce_cnt_t'(1) : t;
  endfunction

  // The equality is reached on this increment and did not hold before it.
  function automatic logic ce_first_equal(input ce_cnt_t cur, input ce_cnt_t thr);
    return (ce_sat_inc(cur) == ce_eff_thr(thr)) && (cur != ce_eff_thr(thr));
  endfunction
endpackage

// File: rtl/ce_cfg_regs.sv
module ce_cfg_regs
  import ce_bank_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned GEN_BIT   = 10,
  parameter int unsigned BEN_BIT   = 30,
  parameter int unsigned THR_LSB   = 0,
  parameter bit          SUPPORTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              glob_en,
  output logic              bank_en,
  output ce_cnt_t           thr
);
  logic cap_wr;
  logic ctl_wr;

  assign cap_wr = wr_en && (wr_sel == SEL_CAP);
  assign ctl_wr = wr_en && (wr_sel == SEL_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
    end else if (cap_wr) begin
      glob_en <= wr_data[GEN_BIT];
    end
  end

  generate
    if (SUPPORTED) begin : g_thr_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          thr     <= '0;
          bank_en <= 1'b0;
        end else if (ctl_wr) begin
          thr     <= wr_data[THR_LSB +: CE_CNT_W];
          bank_en <= wr_data[BEN_BIT];
        end
      end
    end else begin : g_thr_absent
      assign thr     = '0;
      assign bank_en = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ce_status_counter.sv
module ce_status_counter
  import ce_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ce_strobe,
  input  logic    sts_wr,
  input  logic    wr_valid,
  input  ce_cnt_t wr_count,
  output logic    valid,
  output ce_cnt_t count,
  output logic    inc_fire
);
  // A status write wins over a simultaneous error pulse.
  assign inc_fire = ce_strobe && !sts_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      count <= '0;
    end else if (sts_wr) begin
      valid <= wr_valid;
      count <= wr_valid ? wr_count : '0;
    end else if (inc_fire) begin
      valid <= 1'b1;
      count <= ce_sat_inc(count);
    end
  end
endmodule

// File: rtl/ce_irq_fanout.sv
module ce_irq_fanout
  import ce_bank_pkg::*;
#(
  parameter int unsigned N_TGT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_fire,
  input  ce_cnt_t          count,
  input  ce_cnt_t          thr,
  input  logic             glob_en,
  input  logic             bank_en,
  input  logic [N_TGT-1:0] share_mask,
  output logic             hit,
  output logic [N_TGT-1:0] irq
);
  assign hit = inc_fire && glob_en && bank_en && ce_first_equal(count, thr);

  generate
    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          irq[t] <= 1'b0;
        end else begin
          irq[t] <= hit && share_mask[t];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ce_threshold_bank.sv
module ce_threshold_bank
  import ce_bank_pkg::*;
#(
  parameter int unsigned N_TGT     = 4,
  parameter int unsigned GEN_BIT   = 10,
  parameter int unsigned BEN_BIT   = 30,
  parameter int unsigned THR_LSB   = 0,
  parameter int unsigned CNT_LSB   = 38,
  parameter int unsigned VALID_BIT = 63,
  parameter bit          SUPPORTED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_strobe,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [63:0]      wr_data,
  input  logic [N_TGT-1:0] share_mask,
  output logic [31:0]      cap_rd,
  output logic [31:0]      ctl_rd,
  output logic [63:0]      status_rd,
  output logic [N_TGT-1:0] irq
);
  localparam int unsigned DATA_W = 64;

  logic    glob_en;
  logic    bank_en;
  ce_cnt_t thr;
  logic    sts_wr;
  logic    valid;
  ce_cnt_t count;
  logic    inc_fire;
  logic    hit_w;

  assign sts_wr = wr_en && (wr_sel == SEL_STS);

  ce_cfg_regs #(
    .DATA_W(DATA_W), .GEN_BIT(GEN_BIT), .BEN_BIT(BEN_BIT),
    .THR_LSB(THR_LSB), .SUPPORTED(SUPPORTED)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .glob_en(glob_en), .bank_en(bank_en), .thr(thr)
  );

  ce_status_counter u_sts (
    .clk(clk), .rst_n(rst_n), .ce_strobe(ce_strobe), .sts_wr(sts_wr),
    .wr_valid(wr_data[VALID_BIT]), .wr_count(wr_data[CNT_LSB +: CE_CNT_W]),
    .valid(valid), .count(count), .inc_fire(inc_fire)
  );

  ce_irq_fanout #(.N_TGT(N_TGT)) u_irq (
    .clk(clk), .rst_n(rst_n), .inc_fire(inc_fire), .count(count), .thr(thr),
    .glob_en(glob_en), .bank_en(bank_en), .share_mask(share_mask),
    .hit(hit_w), .irq(irq)
  );

  always_comb begin
    cap_rd                       = '0;
    cap_rd[GEN_BIT]              = glob_en;
    ctl_rd                       = '0;
    ctl_rd[THR_LSB +: CE_CNT_W]  = thr;
    ctl_rd[BEN_BIT]              = bank_en;
    status_rd                    = '0;
    status_rd[CNT_LSB +: CE_CNT_W] = count;
    status_rd[VALID_BIT]         = valid;
  end
endmodule

// File: rtl/ce_bank_checker.sv
module ce_bank_checker
  import ce_bank_pkg::*;
#(
  parameter int unsigned N_TGT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_strobe,
  input logic             sts_wr,
  input logic             wr_valid,
  input logic             glob_en,
  input logic             bank_en,
  input logic             valid,
  input ce_cnt_t          count,
  input logic             hit,
  input logic [N_TGT-1:0] share_mask,
  input logic [N_TGT-1:0] irq
);
  assert_irq_needs_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> $past(glob_en && bank_en));

  assert_inc_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_strobe) && !$past(sts_wr) && ($past(count) != '1))
      |-> (count == ce_cnt_t'($past(count) + 1'b1)) && valid);

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(count) == '1) && !$past(sts_wr)) |-> (count == '1));

  assert_irq_follows_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit) |-> (irq == $past(share_mask)));

  assert_irq_only_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hit) |-> (irq == '0));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |=> (irq == '0));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_wr) && !$past(wr_valid)) |-> ((count == '0) && !valid));
endmodule

bind ce_threshold_bank ce_bank_checker #(.N_TGT(N_TGT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_strobe(ce_strobe), .sts_wr(sts_wr),
  .wr_valid(wr_data[VALID_BIT]), .glob_en(glob_en), .bank_en(bank_en),
  .valid(valid), .count(count), .hit(hit_w), .share_mask(share_mask), .irq(irq)
);

// File: tb/test_ce_threshold_bank.sv
module test_ce_threshold_bank;
  localparam int CLK_P = 10;
  localparam int NT    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_strobe = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd3;
  logic [63:0]   wr_data = '0;
  logic [NT-1:0] share_mask = '0;
  logic [31:0]   cap_rd, ctl_rd, cap_rd_n, ctl_rd_n;
  logic [63:0]   status_rd, status_rd_n;
  logic [NT-1:0] irq, irq_n;

  ce_threshold_bank #(.N_TGT(NT)) i_ce_threshold_bank (
    .clk(clk), .rst_n(rst_n), .ce_strobe(ce_strobe), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .share_mask(share_mask),
    .cap_rd(cap_rd), .ctl_rd(ctl_rd), .status_rd(status_rd), .irq(irq)
  );

  ce_threshold_bank #(.N_TGT(NT), .SUPPORTED(1'b0)) i_ce_threshold_bank_nosup (
    .clk(clk), .rst_n(rst_n), .ce_strobe(ce_strobe), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .share_mask(share_mask),
    .cap_rd(cap_rd_n), .ctl_rd(ctl_rd_n), .status_rd(status_rd_n), .irq(irq_n)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // Reference model state
  int m_gen = 0, m_en = 0, m_thr = 0, m_valid = 0, m_cnt = 0;
  int m_irq = 0;

  function automatic logic [63:0] sts_word(input int v, input int c);
    return (64'(v) << 63) | (64'(c & 32'h7fff) << 38);
  endfunction

  task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, got, exp);
    end
  endtask

  task automatic compare();
    check("cap", 64'(cap_rd), 64'(m_gen) << 10);
    check("ctl", 64'(ctl_rd), 64'(m_thr) | (64'(m_en) << 30));
    check("status", status_rd, sts_word(m_valid, m_cnt));
    check("irq", 64'(irq), 64'(m_irq));
    check("R9 nosup ctl", 64'(ctl_rd_n), 64'd0);
    check("R9 nosup irq", 64'(irq_n), 64'd0);
  endtask

  task automatic model(input logic s, input logic w, input logic [1:0] sel,
                       input logic [63:0] d, input logic [NT-1:0] msk);
    int nxt_irq = 0;
    int eff = (m_thr == 0) ? 1 : m_thr;
    if (s && !(w && sel == 2'd2)) begin
      int nv = (m_cnt == 32767) ? 32767 : m_cnt + 1;
      if (nv == eff && m_cnt != eff && m_gen != 0 && m_en != 0) nxt_irq = int'(msk);
      m_cnt = nv;
      m_valid = 1;
    end
    if (w) begin
      case (sel)
        2'd0: m_gen = int'(d[10]);
        2'd1: begin m_thr = int'(d[14:0]); m_en = int'(d[30]); end
        2'd2: begin m_valid = int'(d[63]); m_cnt = d[63] ? int'(d[52:38]) : 0; end
        default: ;
      endcase
    end
    m_irq = nxt_irq;
  endtask

  task automatic step(input logic s, input logic w, input logic [1:0] sel, input logic [63:0] d);
    ce_strobe = s; wr_en = w; wr_sel = sel; wr_data = d;
    @(posedge clk);
    model(s, w, sel, d, share_mask);
    @(negedge clk);
    ce_strobe = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    compare();
  endtask

  task automatic err(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd3, '0);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    step(1'b0, 1'b1, sel, d);
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1 reset";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    cur_req = "R2 R3 counting with enables off";
    share_mask = 4'b0101;
    wr(2'd1, 64'd3);                 // threshold 3, bank enable off
    err(5);
    wr(2'd2, 64'd0);
    cur_req = "R2 global only";
    wr(2'd0, 64'h400);
    err(4);
    wr(2'd2, 64'd0);
    cur_req = "R2 bank only";
    wr(2'd0, 64'd0);
    wr(2'd1, 64'h4000_0003);
    err(4);
    wr(2'd2, 64'd0);

    cur_req = "R5 fire at threshold with fan-out";
    wr(2'd0, 64'h400);
    err(4);
    share_mask = 4'b1010;
    wr(2'd2, 64'd0);
    err(3);

    cur_req = "R6 software load equal to threshold";
    wr(2'd2, sts_word(1, 3));
    err(2);
    cur_req = "R6 load just below then error";
    wr(2'd2, sts_word(1, 2));
    err(1);

    cur_req = "R8 status write beats error";
    step(1'b1, 1'b1, 2'd2, 64'd0);
    step(1'b1, 1'b1, 2'd2, sts_word(1, 9));
    wr(2'd2, 64'd0);

    cur_req = "R7 zero threshold acts as one";
    share_mask = 4'b1111;
    wr(2'd1, 64'h4000_0000);
    err(3);

    cur_req = "R4 R6 saturation at max threshold";
    share_mask = 4'b0110;
    wr(2'd1, 64'h4000_7fff);
    wr(2'd2, sts_word(1, 32765));
    err(5);

    cur_req = "R8 clear after saturation";
    wr(2'd2, 64'd0);
    err(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule